// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block steers a digitally controlled high-frequency oscillator onto a programmed frequency. Running entirely in the oscillator's own clock domain, it brings a slow reference clock (nominally 32.768 kHz) across through a synchronizer. Each synchronized rising reference edge is counted, and every `REF_DIV` of them (16 by default, giving a 2048 Hz window) closes a measurement window. The number of oscillator cycles inside the window is compared with a 13-bit target. The difference, scaled by a fixed power-of-two gain, moves an 18-bit control code that saturates at both ends.

A lock flag reports when the loop has settled. An optional spread-spectrum mode draws one value per window from an 8-bit pseudo-random sequence and adds it, centred on zero and scaled by a selectable shift, to the code sent to the oscillator. The code the loop itself integrates is never dithered, so spreading does not bias the frequency average the loop converges on.

At 8 MHz one window holds about 3906 cycles, so a single count is roughly 256 ppm. Over the 8–16 MHz range the count never exceeds the 13-bit target space.

Top module: `fll_ctrl`

## Requirements
- R1: After a synchronous reset, `osc_code` equals `CODE_INIT` (default 131072) and `locked` is 0.
- R2: A window ends on every `REF_DIV`-th synchronized rising edge of `ref_clk`. The count is the number of `osc_clk` cycles between two consecutive window ends. The first window end after reset only starts measuring and changes neither the code nor the lock flag.
- R3: At each later window end with `loop_en` high, the stored code becomes code + (freq_set − count)·2^GAIN_SHL. With spreading off, this value appears on `osc_code`.
- R4: The code update saturates at 0 and at 2^18−1 and never wraps around.
- R5: A window end with `loop_en` low leaves the stored code unchanged.
- R6: `locked` is set at the 4th consecutive window end with `loop_en` high and |freq_set − count| ≤ 1. It is cleared at any window end with a larger error or with `loop_en` low, and it changes only at window ends.
- R7: The spreading sequence is 8 bits, seeded to 0x01, and never reaches zero. On each window end with `spread_en` high it steps to {s[6:0], s[7]^s[5]^s[4]^s[3]}, and `osc_code` becomes clamp(code + (s_new − 128)·2^spread_amp) over [0, 2^18−1].
- R8: The dither never enters the stored code. At a window end with `spread_en` low, `osc_code` equals the undithered stored code exactly.
- R9: While `spread_en` is low the sequence does not advance, so re-enabling continues from the value it last held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all state runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to `osc_clk` |
| loop_en | input | 1 | Allows code updates at window ends |
| freq_set | input | 13 | Target oscillator cycles per window |
| spread_en | input | 1 | Enables pseudo-random dither of the output code |
| spread_amp | input | 2 | Left shift applied to the centred dither value |
| osc_code | output | 18 | Control code driven to the oscillator |
| locked | output | 1 | Loop settled within one count for four windows |

## Verification
A mistake in the cycle counter, the window divider or the error arithmetic shows at the next window end after the first full one: `osc_code` lands on a value other than code + error·2^GAIN_SHL. A fault in the lock streak shows no later than four windows after it occurs. A sequence generator that steps at the wrong time, or that leaks dither into the stored code, shifts `osc_code` at the first window where spreading is switched off or back on. Because every window in the bench has an exact, known length, each window end has one correct output.

// File: rtl/fll_pkg.sv
package fll_pkg;

    localparam int CODE_W       = 18;
    localparam int TGT_W        = 13;
    localparam int CNT_W        = TGT_W + 1;
    localparam int ERR_W        = CNT_W + 1;
    localparam int PRN_W        = 8;
    localparam int AMP_W        = 2;
    localparam int ACC_W        = 32;
    localparam int LOCK_WINDOWS = 4;
    localparam int LK_W         = $clog2(LOCK_WINDOWS + 1);

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic [TGT_W-1:0]         tgt_t;
    typedef logic [CNT_W-1:0]         cnt_t;
    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [PRN_W-1:0]         prn_t;

    // Result of one measurement window
    typedef struct packed {
        logic full;   // window was complete and may drive an update
        cnt_t count;  // oscillator cycles in the window
    } meas_t;

    typedef enum logic {
        WS_PRIME = 1'b0,
        WS_RUN   = 1'b1
    } win_state_t;

    localparam acc_t CODE_MAX_S = acc_t'((64'd1 << CODE_W) - 64'd1);
    localparam acc_t PRN_MID_S  = acc_t'(1 << (PRN_W - 1));
    localparam prn_t PRN_SEED   = prn_t'(1);

    function automatic code_t clamp_code(input acc_t v);
        if (v < 0)
            return '0;
        else if (v > CODE_MAX_S)
            return '1;
        else
            return v[CODE_W-1:0];
    endfunction

    function automatic prn_t prn_step(input prn_t s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic err_small(input err_t e);
        return (e >= -1) && (e <= 1);
    endfunction

endpackage

// File: rtl/fll_ref_window.sv
module fll_ref_window
    import fll_pkg::*;
#(
    parameter int REF_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic win_end,
    output logic win_full
);
    localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);

    logic [2:0]       sync_q;
    logic             ref_rise;
    logic [DIV_W-1:0] div_q;
    win_state_t       state_q;

    // Two flops for metastability, a third to find the rising edge
    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], ref_in};
    end

    assign ref_rise = sync_q[1] & ~sync_q[2];
    assign win_end  = ref_rise && (div_q == DIV_LAST);
    assign win_full = win_end && (state_q == WS_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            state_q <= WS_PRIME;
        end else if (ref_rise) begin
            if (div_q == DIV_LAST) begin
                div_q   <= '0;
                state_q <= WS_RUN;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fll_edge_counter.sv
module fll_edge_counter
    import fll_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  win_end,
    input  logic  win_full,
    output meas_t meas
);
    cnt_t cnt_q;
    cnt_t cnt_inc;

    // Saturating increment; the current cycle belongs to the closing window
    assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

    assign meas.full  = win_full;
    assign meas.count = cnt_inc;

    always_ff @(posedge clk) begin
        if (rst || win_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_inc;
    end

endmodule

// File: rtl/fll_loop_filter.sv
module fll_loop_filter
    import fll_pkg::*;
#(
    parameter int    GAIN_SHL  = 4,
    parameter code_t CODE_INIT = code_t'(1 << (CODE_W - 1))
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  loop_en,
    input  tgt_t  freq_set,
    input  meas_t meas,
    output code_t code_q,
    output code_t code_n,
    output err_t  err,
    output logic  locked
);
    acc_t             tgt_x, cnt_x, err_x, code_x, acc;
    logic [LK_W-1:0]  streak_q, streak_n;
    logic             apply;

    assign tgt_x  = {{(ACC_W-TGT_W){1'b0}}, freq_set};
    assign cnt_x  = {{(ACC_W-CNT_W){1'b0}}, meas.count};
    assign err_x  = tgt_x - cnt_x;
    assign err    = err_x[ERR_W-1:0];
    assign code_x = {{(ACC_W-CODE_W){1'b0}}, code_q};
    assign acc    = code_x + (err_x <<< GAIN_SHL);
    assign apply  = meas.full && loop_en;
    assign code_n = apply ? clamp_code(acc) : code_q;

    always_comb begin
        streak_n = streak_q;
        if (meas.full) begin
            if (!loop_en || !err_small(err))
                streak_n = '0;
            else if (streak_q != LK_W'(LOCK_WINDOWS))
                streak_n = streak_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= CODE_INIT;
            streak_q <= '0;
            locked   <= 1'b0;
        end else begin
            code_q   <= code_n;
            streak_q <= streak_n;
            if (meas.full)
                locked <= (streak_n == LK_W'(LOCK_WINDOWS));
        end
    end

endmodule

// File: rtl/fll_spread.sv
module fll_spread
    import fll_pkg::*;
#(
    parameter code_t CODE_INIT = code_t'(1 << (CODE_W - 1))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spread_en,
    input  logic [AMP_W-1:0] spread_amp,
    input  logic             win_full,
    input  code_t            code_n,
    output code_t            osc_code,
    output prn_t             prn_q
);
    prn_t  prn_n;
    acc_t  prn_x, code_x, dith, out_x;
    code_t out_n;

    assign prn_n  = (win_full && spread_en) ? prn_step(prn_q) : prn_q;
    assign prn_x  = {{(ACC_W-PRN_W){1'b0}}, prn_n};
    assign dith   = (prn_x - PRN_MID_S) <<< spread_amp;
    assign code_x = {{(ACC_W-CODE_W){1'b0}}, code_n};
    assign out_x  = code_x + dith;
    assign out_n  = spread_en ? clamp_code(out_x) : code_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prn_q    <= PRN_SEED;
            osc_code <= CODE_INIT;
        end else begin
            prn_q <= prn_n;
            if (win_full)
                osc_code <= out_n;
        end
    end

endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
    import fll_pkg::*;
#(
    parameter int    REF_DIV   = 16,
    parameter int    GAIN_SHL  = 4,
    parameter code_t CODE_INIT = code_t'(1 << (CODE_W - 1))
) (
    input  logic              osc_clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              loop_en,
    input  logic [TGT_W-1:0]  freq_set,
    input  logic              spread_en,
    input  logic [AMP_W-1:0]  spread_amp,
    output logic [CODE_W-1:0] osc_code,
    output logic              locked
);
    logic  win_end, win_full;
    meas_t meas;
    code_t code_q, code_n;
    err_t  err_s;
    prn_t  prn_q;

    fll_ref_window #(.REF_DIV(REF_DIV)) u_win (
        .clk      (osc_clk),
        .rst      (rst),
        .ref_in   (ref_clk),
        .win_end  (win_end),
        .win_full (win_full)
    );

    fll_edge_counter u_cnt (
        .clk      (osc_clk),
        .rst      (rst),
        .win_end  (win_end),
        .win_full (win_full),
        .meas     (meas)
    );

    fll_loop_filter #(.GAIN_SHL(GAIN_SHL), .CODE_INIT(CODE_INIT)) u_loop (
        .clk      (osc_clk),
        .rst      (rst),
        .loop_en  (loop_en),
        .freq_set (freq_set),
        .meas     (meas),
        .code_q   (code_q),
        .code_n   (code_n),
        .err      (err_s),
        .locked   (locked)
    );

    fll_spread #(.CODE_INIT(CODE_INIT)) u_spread (
        .clk        (osc_clk),
        .rst        (rst),
        .spread_en  (spread_en),
        .spread_amp (spread_amp),
        .win_full   (win_full),
        .code_n     (code_n),
        .osc_code   (osc_code),
        .prn_q      (prn_q)
    );

endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk
    import fll_pkg::*;
#(
    parameter code_t CODE_INIT = code_t'(1 << (CODE_W - 1))
) (
    input logic  clk,
    input logic  rst,
    input logic  loop_en,
    input logic  spread_en,
    input logic  win_full,
    input code_t code_q,
    input err_t  err,
    input prn_t  prn_q,
    input code_t osc_code,
    input logic  locked
);
    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (past_valid && $past(rst)) |-> (osc_code == CODE_INIT && !locked));

    // R4
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q == '1 && win_full && loop_en && !err[ERR_W-1]) |=> (code_q == '1));

    // R4
    sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q == '0 && win_full && loop_en && (err[ERR_W-1] || err == '0)) |=> (code_q == '0));

    // R5
    hold_code_chk: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(!rst) && $past(!loop_en)) |-> $stable(code_q));

    // R6
    lock_window_chk: assert property (@(posedge clk) disable iff (rst)
        !win_full |=> $stable(locked));

    // R7
    prn_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        prn_q != '0);

    // R8
    clean_code_chk: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(win_full && !spread_en)) |-> (osc_code == code_q));

    // R9
    prn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !spread_en |=> $stable(prn_q));

endmodule

bind fll_ctrl fll_ctrl_chk #(.CODE_INIT(CODE_INIT)) u_chk (
    .clk       (osc_clk),
    .rst       (rst),
    .loop_en   (loop_en),
    .spread_en (spread_en),
    .win_full  (win_full),
    .code_q    (code_q),
    .err       (err_s),
    .prn_q     (prn_q),
    .osc_code  (osc_code),
    .locked    (locked)
);

// File: tb/fll_ctrl_test.sv
module fll_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_DIV    = 4;
    localparam int HALF       = 8;
    localparam int GAIN       = 6;
    localparam int WIN        = 2 * HALF * REF_DIV;
    localparam int INIT       = 131072;
    localparam int MAXC       = 262143;

    logic        clk = 1'b0, rst = 1'b1, ref_clk = 1'b0;
    logic        loop_en = 1'b0, spread_en = 1'b0;
    logic [12:0] freq_set = '0;
    logic [1:0]  spread_amp = '0;
    logic [17:0] osc_code;
    logic        locked;

    int n_run = 0, n_fail = 0;
    int mcode = INIT, mout = INIT, mstreak = 0, mlfsr = 1;
    bit mlock = 0, primed = 0, done = 0;
    int ph = 0;

    fll_ctrl #(.REF_DIV(REF_DIV), .GAIN_SHL(GAIN)) uut (
        .osc_clk(clk), .rst(rst), .ref_clk(ref_clk), .loop_en(loop_en),
        .freq_set(freq_set), .spread_en(spread_en), .spread_amp(spread_amp),
        .osc_code(osc_code), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference derived in whole oscillator cycles: every window is exactly WIN cycles
    always @(negedge clk) begin
        if (ph == HALF - 1) begin
            ph <= 0;
            ref_clk <= ~ref_clk;
        end else begin
            ph <= ph + 1;
        end
    end

    function automatic int clampc(input int v);
        if (v < 0) return 0;
        if (v > MAXC) return MAXC;
        return v;
    endfunction

    function automatic int prn_next(input int s);
        int b;
        b = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s << 1) & 8'hFE) | b;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int err;
        err = int'(freq_set) - WIN;
        if (loop_en) begin
            mcode = clampc(mcode + err * (1 << GAIN));
            if (err >= -1 && err <= 1) mstreak = (mstreak < 4) ? mstreak + 1 : 4;
            else mstreak = 0;
            mlock = (mstreak == 4);
        end else begin
            mstreak = 0;
            mlock = 0;
        end
        if (spread_en) begin
            mlfsr = prn_next(mlfsr);
            mout = clampc(mcode + (mlfsr - 128) * (1 << spread_amp));
        end else begin
            mout = mcode;
        end
    endtask

    task automatic window(input string tag);
        repeat (REF_DIV) @(posedge ref_clk);
        if (primed) model_step();
        primed = 1;
        repeat (8) @(posedge clk);
        #1;
        check(tag, int'(osc_code), mout, "osc_code");
        check(tag, int'(locked), int'(mlock), "locked");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (10) @(posedge clk);
        @(negedge ref_clk);
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check("R1", int'(osc_code), INIT, "osc_code");
        check("R1", int'(locked), 0, "locked");

        // R2: first window only primes, even with a huge target
        loop_en = 1'b1;
        freq_set = 13'd8191;
        window("R2");
        freq_set = 13'(WIN);
        // R2, R6: exact count gives zero error, lock after four windows
        for (int i = 0; i < 5; i++) window("R6");
        // R3: error of +1 moves code, lock holds
        freq_set = 13'(WIN + 1);
        for (int i = 0; i < 3; i++) window("R3");
        // R6: larger error clears lock
        freq_set = 13'(WIN + 6);
        for (int i = 0; i < 2; i++) window("R6");
        freq_set = 13'(WIN - 4);
        for (int i = 0; i < 3; i++) window("R3");
        // R5: loop disabled holds code
        loop_en = 1'b0;
        freq_set = 13'd0;
        for (int i = 0; i < 3; i++) window("R5");
        // R4: saturate high
        loop_en = 1'b1;
        freq_set = 13'd8191;
        for (int i = 0; i < 3; i++) window("R4");
        // R4: ramp down to zero and stay there
        freq_set = 13'd0;
        for (int i = 0; i < 68; i++) window("R4");
        // back to the middle of the range
        freq_set = 13'(WIN + 2048);
        window("R3");
        // R7: spreading at every amplitude
        freq_set = 13'(WIN);
        spread_en = 1'b1;
        for (int a = 0; a < 4; a++) begin
            spread_amp = 2'(a);
            for (int i = 0; i < 3; i++) window("R7");
        end
        // R8: off again returns the clean code
        spread_en = 1'b0;
        for (int i = 0; i < 2; i++) window("R8");
        // R9: sequence resumes where it stopped
        spread_en = 1'b1;
        spread_amp = 2'd1;
        for (int i = 0; i < 3; i++) window("R9");
        // R8: dither does not accumulate while the loop is off
        loop_en = 1'b0;
        for (int i = 0; i < 3; i++) window("R8");
        spread_en = 1'b0;
        window("R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule